// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port Bank

This block gives a bus master per-bit control of a group of 8-bit bidirectional pad ports. Each port has a small register group on a simple write-strobe/address bus: a configuration byte, an output data byte and a read-only byte that returns the synchronised pad levels. For each bit, the pair of configuration and data bits picks one of four pad behaviours: floating input, input with weak pull-up, driven low or driven high. The block turns this choice into pad output-enable, output-value and pull-up-enable signals.

The last bidirectional port is a control variant. Its two top data bits are not stored. Writing a one to either of them fires a one-cycle request to enter a low-power state: bit 7 requests halt and bit 6 requests idle. Its two top configuration bits are stored and brought out as option levels: bit 6 selects the alternate serial-clock phase and bit 7 enables a start-up delay after halt. The pads of those two bits are never driven or pulled, and their pin levels can still be read. A separate output-only byte comes out of reset as all ones.

Top module: `gpio_bank`

## Requirements
- R1: For each bidirectional bit, {config, data} selects the pad mode: 00 gives oe=0, out=0, pu=0; 01 gives oe=0, out=0, pu=1; 10 gives oe=1, out=0; 11 gives oe=1, out=1. Output-enable and pull-up are never both active.
- R2: Port p (p = 0 to NPORT-1) uses address 4p for configuration, 4p+1 for output data and 4p+2 for the pin byte. Configuration and data read back what was last written.
- R3: After reset every configuration and data register reads zero, and all pads are undriven with no pull-up.
- R4: A write is captured at the rising clock edge where bus_wr is high. Pad and output signals change only after such an edge.
- R5: A read of a pin byte returns the pad input after two register stages. A change of pad_in before edge k shows up after edge k+1.
- R6: On the control port (last port, data address 4(NPORT-1)+1), a write with bit 7 set raises halt_req for the single cycle after the write edge. A write with bit 7 clear leaves it low.
- R7: The same write with bit 6 set raises idle_req for that single cycle.
- R8: Data bits 6 and 7 of the control port are not stored and always read zero.
- R9: Configuration bits 6 and 7 of the control port are stored, read back, and drive sk_alt_phase (bit 6) and wake_delay_en (bit 7). The pads of those two bits are never driven or pulled up.
- R10: The output-only byte at address 4·NPORT+1 drives fixed_out, resets to all ones, and reads back what was last written.
- R11: Offset 3 of every group, offsets 0, 2 and 3 of the output-only group, and all higher addresses read zero. Writes there change nothing, and writes to pin bytes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| pad_in | input | NPORT·DW | Pad input levels, port p in slice p |
| pad_oe | output | NPORT·DW | Pad output enable |
| pad_out | output | NPORT·DW | Pad drive value |
| pad_pu | output | NPORT·DW | Weak pull-up enable |
| fixed_out | output | DW | Output-only byte |
| halt_req | output | 1 | One-cycle halt entry request |
| idle_req | output | 1 | One-cycle idle entry request |
| sk_alt_phase | output | 1 | Alternate serial-clock phase select |
| wake_delay_en | output | 1 | Clock start-up delay after halt enable |

## Verification
The bench builds the block with DW=8 and NPORT=2, so there is one ordinary port at addresses 0 to 2, the control port at 4 to 6 and the output-only byte at 9. With this setup the control variant, the ordinary variant and the output-only byte can each be exercised directly. It also leaves both kinds of unmapped address to probe: offset 3 of each group, and the empty slots of the output-only group. The upper pin bits of the control port can be checked against their pads with all eight bits in view.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_DAT = 2'd1,
    SEL_PIN = 2'd2,
    SEL_GAP = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic oe;
    logic drv;
    logic pu;
  } pad_ctl_t;

  function automatic pad_ctl_t decode_mode(input logic cfg, input logic dat);
    pad_ctl_t r;
    r.oe  = cfg;
    r.drv = cfg & dat;
    r.pu  = ~cfg & dat;
    return r;
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= 2'b00;
    else           sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_out = sh_q[1];
endmodule

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_pkg::*;
#(
  parameter int DW      = 8,
  parameter bit SPECIAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cfg,
  input  logic          wr_dat,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] cfg_rd,
  output logic [DW-1:0] dat_rd,
  output logic [DW-1:0] pin_rd,
  output logic [DW-1:0] pad_oe,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_pu,
  output logic          halt_pulse,
  output logic          idle_pulse
);
  localparam int NIO = SPECIAL ? DW - 2 : DW;

  function automatic logic [DW-1:0] io_mask();
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < NIO);
    return m;
  endfunction

  localparam logic [DW-1:0] KEEP = io_mask();

  logic [DW-1:0] cfg_q, cfg_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [1:0]    req_q, req_d;

  always_comb begin
    cfg_d = cfg_q;
    dat_d = dat_q;
    if (wr_cfg) cfg_d = wdata;
    if (wr_dat) dat_d = wdata & KEEP;
  end

  generate
    if (SPECIAL) begin : g_req
      always_comb req_d = wr_dat ? wdata[DW-1 -: 2] : 2'b00;
    end else begin : g_noreq
      always_comb req_d = 2'b00;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      dat_q <= '0;
      req_q <= 2'b00;
    end else begin
      cfg_q <= cfg_d;
      dat_q <= dat_d;
      req_q <= req_d;
    end
  end

  generate
    for (genvar b = 0; b < DW; b++) begin : g_bit
      if (b < NIO) begin : g_io
        pad_ctl_t c;
        assign c          = decode_mode(cfg_q[b], dat_q[b]);
        assign pad_oe[b]  = c.oe;
        assign pad_out[b] = c.drv;
        assign pad_pu[b]  = c.pu;
      end else begin : g_ctl
        assign pad_oe[b]  = 1'b0;
        assign pad_out[b] = 1'b0;
        assign pad_pu[b]  = 1'b0;
      end
    end
  endgenerate

  gpio_sync2 #(.W(DW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pin_rd)
  );

  assign cfg_rd     = cfg_q;
  assign dat_rd     = dat_q;
  assign halt_pulse = req_q[1];
  assign idle_pulse = req_q[0];
endmodule

// File: rtl/gpio_outport.sv
`timescale 1ns/1ps
module gpio_outport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] dat_q, dat_d;

  always_comb dat_d = wr ? wdata : dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '1;
    else        dat_q <= dat_d;
  end

  assign q = dat_q;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NPORT  = 2,
  parameter int ADDR_W = $clog2(4 * (NPORT + 1))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NPORT*DW-1:0] pad_in,
  output logic [NPORT*DW-1:0] pad_oe,
  output logic [NPORT*DW-1:0] pad_out,
  output logic [NPORT*DW-1:0] pad_pu,
  output logic [DW-1:0]       fixed_out,
  output logic                halt_req,
  output logic                idle_req,
  output logic                sk_alt_phase,
  output logic                wake_delay_en
);
  localparam int GW   = ADDR_W - 2;
  localparam int SPEC = NPORT - 1;

  logic           rst_int_n;
  logic [GW-1:0]  grp;
  reg_sel_e       sel;
  logic [DW-1:0]  cfg_a [NPORT];
  logic [DW-1:0]  dat_a [NPORT];
  logic [DW-1:0]  pin_a [NPORT];
  logic [NPORT-1:0] halt_v, idle_v;
  logic           wr_fixed;
  logic [DW-1:0]  rd_mux;

  gpio_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_int_n)
  );

  assign grp = bus_addr[ADDR_W-1:2];
  assign sel = reg_sel_e'(bus_addr[1:0]);

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic wr_c, wr_d;
      assign wr_c = bus_wr && (grp == GW'(p)) && (sel == SEL_CFG);
      assign wr_d = bus_wr && (grp == GW'(p)) && (sel == SEL_DAT);

      gpio_port #(.DW(DW), .SPECIAL(p == SPEC)) u_port (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .wr_cfg    (wr_c),
        .wr_dat    (wr_d),
        .wdata     (bus_wdata),
        .pad_in    (pad_in[p*DW +: DW]),
        .cfg_rd    (cfg_a[p]),
        .dat_rd    (dat_a[p]),
        .pin_rd    (pin_a[p]),
        .pad_oe    (pad_oe[p*DW +: DW]),
        .pad_out   (pad_out[p*DW +: DW]),
        .pad_pu    (pad_pu[p*DW +: DW]),
        .halt_pulse(halt_v[p]),
        .idle_pulse(idle_v[p])
      );
    end
  endgenerate

  assign wr_fixed = bus_wr && (grp == GW'(NPORT)) && (sel == SEL_DAT);

  gpio_outport #(.DW(DW)) u_fixed (
    .clk  (clk),
    .rst_n(rst_int_n),
    .wr   (wr_fixed),
    .wdata(bus_wdata),
    .q    (fixed_out)
  );

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (grp == GW'(p)) begin
        case (sel)
          SEL_CFG: rd_mux = cfg_a[p];
          SEL_DAT: rd_mux = dat_a[p];
          SEL_PIN: rd_mux = pin_a[p];
          default: rd_mux = '0;
        endcase
      end
    end
    if (grp == GW'(NPORT) && sel == SEL_DAT) rd_mux = fixed_out;
  end

  assign bus_rdata     = rd_mux;
  assign halt_req      = |halt_v;
  assign idle_req      = |idle_v;
  assign sk_alt_phase  = cfg_a[SPEC][DW-2];
  assign wake_delay_en = cfg_a[SPEC][DW-1];
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
  parameter int DW     = 8,
  parameter int NPORT  = 2,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic [DW-1:0]       bus_rdata,
  input logic [NPORT*DW-1:0] pad_oe,
  input logic [NPORT*DW-1:0] pad_out,
  input logic [NPORT*DW-1:0] pad_pu,
  input logic [DW-1:0]       fixed_out,
  input logic                halt_req,
  input logic                idle_req
);
  localparam int GW = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] SPEC_DAT = ADDR_W'(4 * (NPORT - 1) + 1);
  localparam int SB = (NPORT - 1) * DW + DW - 2;

  logic gap;
  assign gap = (bus_addr[1:0] == 2'd3)
            || (bus_addr[ADDR_W-1:2] > GW'(NPORT))
            || ((bus_addr[ADDR_W-1:2] == GW'(NPORT)) && (bus_addr[1:0] != 2'd1));

  AST_PAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_pu) == '0) && ((pad_out & ~pad_oe) == '0)); // R1

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) && $stable(fixed_out)); // R4

  AST_HALT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(bus_wr) && ($past(bus_addr) == SPEC_DAT) && $past(bus_wdata[DW-1])); // R6

  AST_IDLE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |-> $past(bus_wr) && ($past(bus_addr) == SPEC_DAT) && $past(bus_wdata[DW-2])); // R7

  AST_CTL_DATA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SPEC_DAT) |-> (bus_rdata[DW-1 -: 2] == 2'b00)); // R8

  AST_CTL_PADS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[SB +: 2] == 2'b00) && (pad_pu[SB +: 2] == 2'b00)); // R9

  AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    gap |-> (bus_rdata == '0)); // R11
endmodule

bind gpio_bank gpio_bank_chk #(.DW(DW), .NPORT(NPORT), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] pad_in;
  logic [15:0] pad_oe, pad_out, pad_pu;
  logic [7:0]  fixed_out;
  logic        halt_req, idle_req, sk_alt_phase, wake_delay_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_bank #(.DW(8), .NPORT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .fixed_out(fixed_out),
    .halt_req(halt_req), .idle_req(idle_req), .sk_alt_phase(sk_alt_phase),
    .wake_delay_en(wake_delay_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R3 pad_oe", pad_oe, 16'h0);
    check("R3 pad_out", pad_out, 16'h0);
    check("R3 pad_pu", pad_pu, 16'h0);
    bus_read(4'd0, d); check("R3 cfg0", d, 8'h00);
    bus_read(4'd1, d); check("R3 dat0", d, 8'h00);
    bus_read(4'd4, d); check("R3 cfg1", d, 8'h00);
    bus_read(4'd5, d); check("R3 dat1", d, 8'h00);
    check("R10 fixed reset", fixed_out, 8'hFF);
    bus_read(4'd9, d); check("R10 fixed read reset", d, 8'hFF);
    check("R6 halt idle at reset", {halt_req, idle_req, sk_alt_phase, wake_delay_en}, 4'h0);
  endtask

  task automatic t_modes;
    logic [7:0] d;
    bus_write(4'd0, 8'hF0);
    bus_write(4'd1, 8'hAA);
    check("R1 port0 oe", pad_oe[7:0], 8'hF0);
    check("R1 port0 out", pad_out[7:0], 8'hA0);
    check("R1 port0 pu", pad_pu[7:0], 8'h0A);
    bus_read(4'd0, d); check("R2 cfg0 readback", d, 8'hF0);
    bus_read(4'd1, d); check("R2 dat0 readback", d, 8'hAA);
    bus_write(4'd4, 8'h3C);
    bus_write(4'd5, 8'h35);
    check("R1 port1 oe", pad_oe[15:8], 8'h3C);
    check("R1 port1 out", pad_out[15:8], 8'h34);
    check("R1 port1 pu", pad_pu[15:8], 8'h01);
    bus_read(4'd5, d); check("R2 dat1 readback", d, 8'h35);
  endtask

  task automatic t_timing;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 8'hFF;
    #1;
    check("R4 before edge", pad_oe[7:0], 8'hF0);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R4 after edge", pad_oe[7:0], 8'hFF);
    check("R4 after edge out", pad_out[7:0], 8'hAA);
  endtask

  task automatic t_pins;
    logic [7:0] d;
    @(negedge clk);
    pad_in = 16'hC35A;
    @(negedge clk);
    bus_read(4'd2, d); check("R5 one stage", d, 8'h00);
    @(negedge clk);
    bus_read(4'd2, d); check("R5 two stages", d, 8'h5A);
    bus_read(4'd6, d); check("R5 control port pins", d, 8'hC3);
  endtask

  task automatic t_special;
    logic [7:0] d;
    bus_write(4'd5, 8'hD2);
    check("R6 halt pulse", halt_req, 1'b1);
    check("R7 idle pulse", idle_req, 1'b1);
    @(negedge clk);
    check("R6 halt single", halt_req, 1'b0);
    check("R7 idle single", idle_req, 1'b0);
    bus_read(4'd5, d); check("R8 upper read zero", d, 8'h12);
    bus_write(4'd5, 8'h80);
    check("R6 halt only", {halt_req, idle_req}, 2'b10);
    bus_write(4'd5, 8'h05);
    check("R6 no request", {halt_req, idle_req}, 2'b00);
    bus_write(4'd4, 8'hFF);
    check("R9 options both", {wake_delay_en, sk_alt_phase}, 2'b11);
    check("R9 pads undriven", {pad_oe[15:14], pad_pu[15:14]}, 4'h0);
    bus_read(4'd4, d); check("R9 cfg readback", d, 8'hFF);
    bus_write(4'd4, 8'h40);
    check("R9 phase only", {wake_delay_en, sk_alt_phase}, 2'b01);
  endtask

  task automatic t_fixed;
    logic [7:0] d;
    bus_write(4'd9, 8'h3C);
    check("R10 fixed write", fixed_out, 8'h3C);
    bus_read(4'd9, d); check("R10 fixed read", d, 8'h3C);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    logic [15:0] oe0, out0, pu0;
    oe0 = pad_oe; out0 = pad_out; pu0 = pad_pu;
    bus_write(4'd3, 8'h77);
    bus_write(4'd7, 8'h77);
    bus_write(4'd8, 8'h77);
    bus_write(4'd10, 8'h77);
    bus_write(4'd11, 8'h77);
    bus_write(4'd2, 8'h77);
    bus_write(4'd6, 8'h77);
    check("R11 pads unchanged", {pad_oe, pad_out, pad_pu}, {oe0, out0, pu0});
    check("R11 fixed unchanged", fixed_out, 8'h3C);
    bus_read(4'd3, d);  check("R11 addr3 zero", d, 8'h00);
    bus_read(4'd8, d);  check("R11 addr8 zero", d, 8'h00);
    bus_read(4'd10, d); check("R11 addr10 zero", d, 8'h00);
    bus_read(4'd14, d); check("R11 addr14 zero", d, 8'h00);
    bus_read(4'd2, d);  check("R11 pin byte unchanged", d, 8'h5A);
    bus_read(4'd0, d);  check("R11 cfg0 unchanged", d, 8'hFF);
    bus_read(4'd4, d);  check("R11 cfg1 unchanged", d, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00; pad_in = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_modes();
    t_timing();
    t_pins();
    t_special();
    t_fixed();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule